// File: doc/BRIEF.md
# Standby-Wake UART Receiver

This block receives asynchronous serial frames on a single line, oversampled by an external baud tick running at OSR times the bit rate. It finds the falling edge of a start bit and confirms it at mid-bit. Each data bit is taken as the majority of three samples near its centre. A frame carries 8 or 9 data bits, least significant bit first. A frame whose stop bit samples high is written to the data register and raises a data-ready flag. A separate idle flag reports that the line has gone quiet after traffic.

On a shared multidrop line, a node that finds a message is not addressed to it can put the receiver into standby. While in standby, frames still pass through the framer but do not touch the data register or the flags. A wake-mode input chooses what ends standby. In idle-line mode, a full frame length of continuous marking ends it, and that quiet period is not reported as an idle event. In address-mark mode, any frame whose top data bit is 1 ends it. In that mode standby clears while the frame is still in flight, and the frame is then delivered as ordinary data.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset, data_o is 0 and rdrf_o, idle_o, overrun_o and standby_o are all 0.
- R2: With long_frame_i=0, a frame made of a low start bit, 8 data bits sent LSB first and a high stop bit loads the byte into data_o[7:0], with data_o[8]=0. It sets rdrf_o by the end of the stop bit.
- R3: With long_frame_i=1, the frame carries 9 data bits, LSB first, and all 9 appear on data_o[8:0].
- R4: A low pulse on rx_i that has ended before the middle of the start bit is not taken as a frame: rdrf_o stays 0.
- R5: A frame whose stop bit samples low does not set rdrf_o.
- R6: A one-cycle pulse on flag_clr_i clears rdrf_o, idle_o and overrun_o.
- R7: A valid frame that arrives while rdrf_o is 1 sets overrun_o and leaves data_o holding the earlier frame.
- R8: With idle_after_stop_i=0, marking bits are counted from the end of the start bit onward. Once the count reaches one frame length (10 bits for 8-bit frames, 11 for 9-bit frames), idle_o sets. It does this once per burst of traffic. It does not set again until a new frame has arrived.
- R9: With idle_after_stop_i=1, the idle count starts only after the stop bit has been sampled, so idle_o sets a full frame length after the stop bit.
- R10: A pulse on standby_set_i sets standby_o. While standby_o is 1, received frames leave data_o, rdrf_o and overrun_o unchanged.
- R11: With wake_addr_i=0, one frame length of marking clears standby_o. The quiet period that wakes the receiver sets neither idle_o nor rdrf_o.
- R12: With wake_addr_i=0, if standby_set_i pulses while the line has already been marking for a frame length, standby_o returns to 0 within two cycles.
- R13: With wake_addr_i=1, standby stays set for frames whose top data bit is 0. The top data bit is bit 7 in 8-bit mode and bit 8 in 9-bit mode. A frame whose top data bit is 1 clears standby_o before its stop bit is sampled, then sets rdrf_o and is delivered on data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | Oversampling enable, OSR pulses per bit |
| wake_addr_i | input | 1 | Wake method: 0 idle line, 1 address mark |
| idle_after_stop_i | input | 1 | Idle count start: 0 after start bit, 1 after stop bit |
| long_frame_i | input | 1 | Data bits per frame: 0 gives 8, 1 gives 9 |
| standby_set_i | input | 1 | One-cycle strobe that enters standby |
| flag_clr_i | input | 1 | One-cycle strobe that clears the status flags |
| data_o | output | DATA_W | Last accepted frame |
| rdrf_o | output | 1 | Received data ready |
| idle_o | output | 1 | Line went idle after traffic |
| overrun_o | output | 1 | Frame arrived while data was still unread |
| standby_o | output | 1 | Receiver in standby |

## Verification
Normal reception is tried with 8-bit and 9-bit frames, with a too-short start pulse and with a low stop bit. These cases separate bit ordering, frame length, start validation and stop validation. An all-ones byte is sent under both idle-count settings, and the flag is checked partway through the quiet period. Only a count that starts after the start bit can have finished by then. Standby is entered in the middle of traffic, and the bench then compares three things: frames that are ignored, a quiet line that wakes the receiver without raising flags, and a line that is already quiet and wakes it at once. Address frames are checked in both frame lengths, with the mark bit placed in the other frame length's top bit as a decoy. A probe during the stop bit shows that standby clears before the frame completes.

// File: rtl/uwr_pkg.sv
package uwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  function automatic logic majority3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction
endpackage

// File: rtl/uwr_sampler.sv
module uwr_sampler
  import uwr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic tick_i,
  output logic rx_s_o,
  output logic vote_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [2:0]             hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
  end

  assign rx_s_o = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hist_q <= '1;
    else if (tick_i) hist_q <= {hist_q[1:0], rx_s_o};
  end

  assign vote_o = majority3(hist_q);
endmodule

// File: rtl/uwr_framer.sv
module uwr_framer
  import uwr_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_s_i,
  input  logic              vote_i,
  input  logic              long_frame_i,
  output logic              busy_o,
  output logic              mark_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OSR / 2 - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              mark_q, done_q;
  logic [IDX_W-1:0]  last_idx;

  assign last_idx = long_frame_i ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      mark_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      mark_q <= 1'b0;
      done_q <= 1'b0;
      if (tick_i) begin
        case (state_q)
          ST_IDLE: begin
            if (!rx_s_i) begin
              state_q <= ST_START;
              cnt_q   <= '0;
            end
          end
          ST_START: begin
            if (cnt_q == CNT_MID) begin
              cnt_q <= '0;
              idx_q <= '0;
              state_q <= rx_s_i ? ST_IDLE : ST_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q <= '0;
              sh_q  <= {vote_i, sh_q[DATA_W-1:1]};
              if (idx_q == last_idx) begin
                mark_q  <= vote_i;
                state_q <= ST_STOP;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q   <= '0;
              done_q  <= vote_i;
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign mark_o = mark_q;
  assign done_o = done_q;
  assign data_o = long_frame_i ? sh_q : {1'b0, sh_q[DATA_W-1:1]};

  p_done_after_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(state_q) == ST_STOP);
  p_mark_before_stop_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_q |-> state_q == ST_STOP);
endmodule

// File: rtl/uwr_idle_det.sv
module uwr_idle_det #(
  parameter int OSR    = 16,
  parameter int DATA_W = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_s_i,
  input  logic busy_i,
  input  logic after_stop_i,
  input  logic long_frame_i,
  output logic line_idle_o,
  output logic idle_pulse_o
);
  localparam int LIM_LONG = (DATA_W + 2) * OSR;
  localparam int CW       = $clog2(LIM_LONG + 1);

  logic [CW-1:0] cnt_q, thr;
  logic          pulse_q;

  assign thr = long_frame_i ? CW'(LIM_LONG) : CW'(LIM_LONG - OSR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (tick_i) begin
        if (!rx_s_i || (after_stop_i && busy_i)) begin
          cnt_q <= '0;
        end else if (cnt_q < thr) begin
          cnt_q   <= cnt_q + 1'b1;
          pulse_q <= (cnt_q == thr - CW'(1));
        end
      end
    end
  end

  assign line_idle_o  = (cnt_q >= thr);
  assign idle_pulse_o = pulse_q;

  p_pulse_at_limit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> line_idle_o);
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx #(
  parameter int OSR         = 16,
  parameter int DATA_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              wake_addr_i,
  input  logic              idle_after_stop_i,
  input  logic              long_frame_i,
  input  logic              standby_set_i,
  input  logic              flag_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rdrf_o,
  output logic              idle_o,
  output logic              overrun_o,
  output logic              standby_o
);
  logic rx_s_w, vote_w, busy_w, mark_w, done_w, line_idle_w, idle_pulse_w;
  logic [DATA_W-1:0] frame_w;

  uwr_sampler #(.SYNC_STAGES(SYNC_STAGES)) i_sampler (
    .clk_i, .rst_ni, .rx_i, .tick_i,
    .rx_s_o (rx_s_w),
    .vote_o (vote_w)
  );

  uwr_framer #(.OSR(OSR), .DATA_W(DATA_W)) i_framer (
    .clk_i, .rst_ni, .tick_i,
    .rx_s_i       (rx_s_w),
    .vote_i       (vote_w),
    .long_frame_i (long_frame_i),
    .busy_o       (busy_w),
    .mark_o       (mark_w),
    .done_o       (done_w),
    .data_o       (frame_w)
  );

  uwr_idle_det #(.OSR(OSR), .DATA_W(DATA_W)) i_idle_det (
    .clk_i, .rst_ni, .tick_i,
    .rx_s_i       (rx_s_w),
    .busy_i       (busy_w),
    .after_stop_i (idle_after_stop_i),
    .long_frame_i (long_frame_i),
    .line_idle_o  (line_idle_w),
    .idle_pulse_o (idle_pulse_w)
  );

  logic              rwu_q, rdrf_q, idle_q, ovr_q, armed_q;
  logic [DATA_W-1:0] data_q;
  logic              wake_hit, accept;

  assign wake_hit = rwu_q && (wake_addr_i ? mark_w : line_idle_w);
  assign accept   = done_w && !rwu_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rwu_q <= 1'b0;
    else if (standby_set_i) rwu_q <= 1'b1;
    else if (wake_hit)      rwu_q <= 1'b0;
  end

  // arm idle reporting only on traffic seen while awake
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       armed_q <= 1'b0;
    else if (standby_set_i)            armed_q <= 1'b0;
    else if (busy_w && !rwu_q)         armed_q <= 1'b1;
    else if (idle_pulse_w && !rwu_q)   armed_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  idle_q <= 1'b0;
    else if (idle_pulse_w && armed_q && !rwu_q)   idle_q <= 1'b1;
    else if (flag_clr_i)                          idle_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdrf_q <= 1'b0;
      data_q <= '0;
    end else if (accept && !rdrf_q) begin
      rdrf_q <= 1'b1;
      data_q <= frame_w;
    end else if (flag_clr_i && !accept) begin
      rdrf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ovr_q <= 1'b0;
    else if (accept && rdrf_q)   ovr_q <= 1'b1;
    else if (flag_clr_i)         ovr_q <= 1'b0;
  end

  assign data_o    = data_q;
  assign rdrf_o    = rdrf_q;
  assign idle_o    = idle_q;
  assign overrun_o = ovr_q;
  assign standby_o = rwu_q;

  p_rdrf_from_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdrf_o) |-> $past(done_w));
  p_clear_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i && !done_w && !idle_pulse_w |=> !rdrf_o && !idle_o && !overrun_o);
  p_overrun_needs_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(rdrf_o));
  p_standby_ignores_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_w && standby_o |=> $stable(data_o) && !$rose(rdrf_o) && !$rose(overrun_o));
  p_quiet_wake_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(standby_o) && !$past(wake_addr_i) |-> !$rose(idle_o) && !$rose(rdrf_o));
  p_instant_wake_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o && !wake_addr_i && line_idle_w && !standby_set_i |=> !standby_o);
  p_mark_wake_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(standby_o) && $past(wake_addr_i) |-> $past(mark_w));
endmodule

// File: tb/test_uart_wake_rx.sv
module test_uart_wake_rx;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_i = 1'b1;
  logic       tick_i = 1'b1;
  logic       wake_addr_i = 1'b0;
  logic       idle_after_stop_i = 1'b0;
  logic       long_frame_i = 1'b0;
  logic       standby_set_i = 1'b0;
  logic       flag_clr_i = 1'b0;
  logic [8:0] data_o;
  logic       rdrf_o, idle_o, overrun_o, standby_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  uart_wake_rx i_uart_wake_rx (
    .clk_i, .rst_ni, .rx_i, .tick_i, .wake_addr_i, .idle_after_stop_i,
    .long_frame_i, .standby_set_i, .flag_clr_i,
    .data_o, .rdrf_o, .idle_o, .overrun_o, .standby_o
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rx_i = b;
    repeat (16) @(negedge clk_i);
  endtask

  task automatic send_frame(input logic [8:0] d, input bit nine, input bit stop_ok);
    drive_bit(1'b0);
    for (int i = 0; i < (nine ? 9 : 8); i++) drive_bit(d[i]);
    drive_bit(stop_ok);
    rx_i = 1'b1;
  endtask

  task automatic gap(input int nbits);
    rx_i = 1'b1;
    repeat (16 * nbits) @(negedge clk_i);
  endtask

  task automatic pulse_clr();
    flag_clr_i = 1'b1;
    @(negedge clk_i);
    flag_clr_i = 1'b0;
  endtask

  task automatic pulse_standby();
    standby_set_i = 1'b1;
    @(negedge clk_i);
    standby_set_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 data", data_o, 0);
    check("R1 rdrf", rdrf_o, 0);
    check("R1 idle", idle_o, 0);
    check("R1 overrun", overrun_o, 0);
    check("R1 standby", standby_o, 0);
  endtask

  task automatic t_basic();
    gap(12);
    send_frame(9'h0A5, 0, 1);
    check("R2 rdrf", rdrf_o, 1);
    check("R2 data", data_o, 9'h0A5);
    pulse_clr();
    check("R6 rdrf cleared", rdrf_o, 0);
    send_frame(9'h03C, 0, 1);
    check("R2 second data", data_o, 9'h03C);
    pulse_clr();
  endtask

  task automatic t_nine();
    long_frame_i = 1'b1;
    send_frame(9'h1A5, 1, 1);
    check("R3 rdrf", rdrf_o, 1);
    check("R3 data", data_o, 9'h1A5);
    pulse_clr();
    long_frame_i = 1'b0;
  endtask

  task automatic t_bad_frames();
    rx_i = 1'b0;
    repeat (3) @(negedge clk_i);
    gap(4);
    check("R4 false start rdrf", rdrf_o, 0);
    send_frame(9'h055, 0, 0);
    gap(4);
    check("R5 framing rdrf", rdrf_o, 0);
    check("R5 data kept", data_o, 9'h1A5);
  endtask

  task automatic t_overrun();
    pulse_clr();
    send_frame(9'h011, 0, 1);
    send_frame(9'h022, 0, 1);
    check("R7 overrun", overrun_o, 1);
    check("R7 data kept", data_o, 9'h011);
    gap(12);
    pulse_clr();
    check("R6 overrun cleared", overrun_o, 0);
    check("R6 idle cleared", idle_o, 0);
    check("R6 rdrf cleared", rdrf_o, 0);
  endtask

  task automatic t_idle_count();
    idle_after_stop_i = 1'b0;
    pulse_clr();
    send_frame(9'h0FF, 0, 1);
    repeat (48) @(negedge clk_i);
    check("R8 idle early count", idle_o, 1);
    pulse_clr();
    gap(20);
    check("R8 idle only once", idle_o, 0);
    idle_after_stop_i = 1'b1;
    send_frame(9'h0FF, 0, 1);
    repeat (48) @(negedge clk_i);
    check("R9 idle not yet", idle_o, 0);
    repeat (200) @(negedge clk_i);
    check("R9 idle after stop count", idle_o, 1);
    idle_after_stop_i = 1'b0;
    pulse_clr();
  endtask

  task automatic t_standby_idle();
    wake_addr_i = 1'b0;
    pulse_clr();
    fork
      begin
        send_frame(9'h000, 0, 1);
        send_frame(9'h03C, 0, 1);
      end
      begin
        repeat (64) @(negedge clk_i);
        pulse_standby();
      end
    join
    check("R10 standby set", standby_o, 1);
    check("R10 rdrf ignored", rdrf_o, 0);
    check("R10 data unchanged", data_o, 9'h0FF);
    gap(12);
    check("R11 woke on idle", standby_o, 0);
    check("R11 idle not set", idle_o, 0);
    check("R11 rdrf not set", rdrf_o, 0);
    send_frame(9'h05A, 0, 1);
    check("R11 awake rdrf", rdrf_o, 1);
    check("R11 awake data", data_o, 9'h05A);
    pulse_clr();
  endtask

  task automatic t_instant();
    wake_addr_i = 1'b0;
    gap(12);
    pulse_standby();
    repeat (2) @(negedge clk_i);
    check("R12 immediate wake", standby_o, 0);
    wake_addr_i = 1'b1;
    pulse_standby();
    repeat (4) @(negedge clk_i);
    check("R13 idle does not wake", standby_o, 1);
  endtask

  task automatic t_addr();
    pulse_clr();
    send_frame(9'h012, 0, 1);
    check("R13 plain frame keeps standby", standby_o, 1);
    check("R13 plain frame rdrf", rdrf_o, 0);
    fork
      send_frame(9'h085, 0, 1);
      begin
        repeat (120) @(negedge clk_i);
        check("R13 standby before mark", standby_o, 1);
        repeat (28) @(negedge clk_i);
        check("R13 standby cleared in stop", standby_o, 0);
        check("R13 rdrf not yet", rdrf_o, 0);
      end
    join
    check("R13 address rdrf", rdrf_o, 1);
    check("R13 address data", data_o, 9'h085);
    pulse_clr();
    long_frame_i = 1'b1;
    pulse_standby();
    send_frame(9'h080, 1, 1);
    check("R13 bit7 not mark in 9-bit", standby_o, 1);
    check("R13 bit7 frame rdrf", rdrf_o, 0);
    send_frame(9'h100, 1, 1);
    check("R13 9-bit mark wakes", standby_o, 0);
    check("R13 9-bit rdrf", rdrf_o, 1);
    check("R13 9-bit data", data_o, 9'h100);
    long_frame_i = 1'b0;
    wake_addr_i = 1'b0;
    pulse_clr();
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_nine();
    t_bad_frames();
    t_overrun();
    t_idle_count();
    t_standby_idle();
    t_instant();
    t_addr();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(negedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule